// File: doc/BRIEF.md
# Nested-Priority Vectored Interrupt Controller

This block gathers eight peripheral interrupt request lines, remembers each new request, and decides which one the processor should service next. Priority is fixed: line 0 ranks highest and line 7 lowest. A single interrupt output tells the processor that a request is waiting and that it outranks every handler already running. The processor answers with a one-cycle acknowledge pulse. One cycle later the block returns the vector of the line it granted. The vector is a programmable base, aligned to 8, with the 3-bit line number in its low bits.

An in-service bit remembers each granted line until the processor sends an end-of-interrupt pulse that names it. While a handler is in service, only a strictly higher-priority line can raise the interrupt again. This gives nested preemption. As a build-time option, one line (line 2 by default) can serve as the link to a second controller. Two chained controllers then give 15 usable lines. When that line is granted, this block drives no vector and instead pulses a cascade-acknowledge output, so that the chained controller supplies the vector.

The vector response is a one-cycle valid pulse with no back-pressure: the processor issues the acknowledge only when it can take the vector in the following cycle. A grant always yields exactly one response beat, either a vector or a cascade acknowledge.

Top module: `vic_prio`

## Requirements
- R1: A request is captured only on a 0-to-1 transition of its line. It stays pending until it is granted, even if the line falls first. A line held high after its grant raises no new request.
- R2: When several lines are pending, the one with the lowest line number wins.
- R3: `intr` is high, starting in the cycle after the capture, exactly when the winning pending line has a lower number than every line in service, or when no line is in service.
- R4: `inta` sampled high while `intr` is high grants the winning line, in one step: the line's pending bit clears and its in-service bit sets. In the next cycle `vec_valid` is high for one cycle, with `vec_data` = `vec_base`*8 + line number.
- R5: A pending line whose number is equal to or greater than the lowest-numbered line in service does not raise `intr`. A pending line with a smaller number does raise it (preemption).
- R6: `eoi` clears only the in-service bit of the line given on `eoi_line`. All other in-service bits are kept.
- R7: With cascading enabled, a grant of the cascade line (line 2) pulses `casc_ack` for one cycle and leaves `vec_valid` low. `vec_valid` and `casc_ack` are never high together.
- R8: During and right after reset, `intr`, `vec_valid` and `casc_ack` are low, and no line is pending or in service.
- R9: `inta` sampled while `intr` is low grants nothing. No response appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Peripheral request lines, bit n = line n |
| vec_base | input | 5 | Upper vector bits (base divided by 8) |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| eoi_line | input | 3 | Line whose in-service bit `eoi` clears |
| vec_valid | output | 1 | `vec_data` holds a vector this cycle |
| vec_data | output | 8 | Vector of the granted line |
| casc_ack | output | 1 | Grant went to the cascade line; the chained controller supplies the vector |

## Verification
The bench drives these corner cases:
- **Line held high after its grant.** A design that latched levels instead of edges would assert `intr` again forever.
- **Short pulse.** A one-cycle pulse must stay pending. A design that dropped the pulse would lose the interrupt.
- **Preemption.** A lower-priority and an equal-priority request arrive while a handler is in service. A design that compared with `<=` or ignored in-service state would nest a handler on top of itself.
- **End-of-interrupt for a line that is not in service.** A design that cleared every in-service bit would release a lower line too early.
- **Cascade grant.** A design without the cascade option would put a stale vector on the bus.
- **Acknowledge with nothing pending.** A design that responded anyway would emit a spurious vector.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/vic_pend.sv
// Rising-edge capture of request lines into a sticky pending register.
module vic_pend
  import vic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t req,
  input  line_vec_t take,
  output line_vec_t pend
);
  line_vec_t req_q;
  line_vec_t rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      // a fresh edge wins over a grant of the same line
      pend  <= (pend & ~take) | rise;
    end
  end
endmodule

// File: rtl/vic_pick.sv
// Fixed-priority picker: lowest set index wins.
module vic_pick
  import vic_pkg::*;
(
  input  line_vec_t bits,
  output logic      hit,
  output line_idx_t idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = line_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/vic_isr.sv
// In-service register: set by grant, cleared by end-of-interrupt.
module vic_isr
  import vic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t set_m,
  input  line_vec_t clr_m,
  output line_vec_t isr
);
  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~clr_m) | set_m;
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter bit          CASC_EN   = 1'b1,
  parameter int unsigned CASC_LINE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       irq_req,
  input  logic [VEC_W-IDX_W-1:0] vec_base,
  output logic                   intr,
  input  logic                   inta,
  input  logic                   eoi,
  input  logic [IDX_W-1:0]       eoi_line,
  output logic                   vec_valid,
  output logic [VEC_W-1:0]       vec_data,
  output logic                   casc_ack
);
  line_vec_t pend, isr, take, eoi_m;
  logic      pend_hit, isr_hit, outranks, grant, is_casc;
  line_idx_t pend_idx, isr_idx;

  vic_pend u_pend (.clk(clk), .rst_n(rst_n), .req(irq_req), .take(take), .pend(pend));
  vic_pick u_pick_p (.bits(pend), .hit(pend_hit), .idx(pend_idx));
  vic_pick u_pick_s (.bits(isr), .hit(isr_hit), .idx(isr_idx));
  vic_isr  u_isr (.clk(clk), .rst_n(rst_n), .set_m(take), .clr_m(eoi_m), .isr(isr));

  assign outranks = pend_hit && (!isr_hit || (pend_idx < isr_idx));
  assign intr     = outranks;
  assign grant    = inta && outranks;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign take[g]  = grant && (pend_idx == line_idx_t'(g));
    assign eoi_m[g] = eoi && (eoi_line == line_idx_t'(g));
  end

  if (CASC_EN) begin : g_casc
    assign is_casc = (pend_idx == line_idx_t'(CASC_LINE));
  end else begin : g_nocasc
    assign is_casc = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      casc_ack  <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= grant && !is_casc;
      casc_ack  <= grant && is_casc;
      if (grant && !is_casc) vec_data <= {vec_base, pend_idx};
    end
  end
endmodule

// File: rtl/vic_prio_chk.sv
module vic_prio_chk
  import vic_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter bit          CASC_EN   = 1'b1,
  parameter int unsigned CASC_LINE = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   intr,
  input logic                   inta,
  input logic                   eoi,
  input logic [IDX_W-1:0]       eoi_line,
  input logic [VEC_W-IDX_W-1:0] vec_base,
  input logic                   vec_valid,
  input logic [VEC_W-1:0]       vec_data,
  input logic                   casc_ack,
  input line_vec_t              pend,
  input line_vec_t              isr
);
  // R4: a grant always produces one response beat
  assert_grant_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && intr) |=> (vec_valid || casc_ack));

  // R4: upper vector bits come from the base in the grant cycle
  assert_vec_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data[VEC_W-1:IDX_W] == $past(vec_base)));

  // R9: no response without a grant
  assert_no_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta && intr) |=> (!vec_valid && !casc_ack));

  // R7: vector and cascade acknowledge are exclusive
  assert_resp_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_valid, casc_ack}));

  // R7: the master never puts the cascade line's vector on the bus
  assert_casc_novec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && CASC_EN) |-> (vec_data[IDX_W-1:0] != line_idx_t'(CASC_LINE)));

  // R1: pending bits only drop on a grant
  assert_pend_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta && intr) |=> ((pend & $past(pend)) == $past(pend)));

  // R5: nothing outranks line 0 in service
  assert_top_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |-> !intr);

  // R6: end-of-interrupt clears the named in-service bit
  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !inta) |=> !isr[$past(eoi_line)]);
endmodule

bind vic_prio vic_prio_chk #(.VEC_W(VEC_W), .CASC_EN(CASC_EN), .CASC_LINE(CASC_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .intr(intr), .inta(inta), .eoi(eoi), .eoi_line(eoi_line),
  .vec_base(vec_base), .vec_valid(vec_valid), .vec_data(vec_data), .casc_ack(casc_ack),
  .pend(pend), .isr(isr)
);

// File: tb/tb_vic_prio.sv
module tb_vic_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic [4:0] vec_base = 5'h0A;
  logic       intr, inta = 1'b0, eoi = 1'b0;
  logic [2:0] eoi_line = '0;
  logic       vec_valid, casc_ack;
  logic [7:0] vec_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vic_prio dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_base(vec_base), .intr(intr),
    .inta(inta), .eoi(eoi), .eoi_line(eoi_line), .vec_valid(vec_valid),
    .vec_data(vec_data), .casc_ack(casc_ack)
  );

  // behavioural reference model
  logic [7:0] mp, mi, mprev;
  logic       mvv, mca;
  int         mvd, mw, mt;

  function automatic int lowest(logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = '0; mi = '0; mprev = '0; mvv = 1'b0; mca = 1'b0; mvd = 0;
    end else begin
      bit g;
      mw = lowest(mp);
      mt = lowest(mi);
      g  = inta && (mw < mt);
      for (int i = 0; i < 8; i++) begin
        mp[i] = (mp[i] && !(g && mw == i)) || (irq_req[i] && !mprev[i]);
        mi[i] = (mi[i] && !(eoi && eoi_line == i)) || (g && mw == i);
      end
      mvv = g && (mw != 2);
      mca = g && (mw == 2);
      if (mvv) mvd = vec_base * 8 + mw;
      mprev = irq_req;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 intr vs model", int'(intr), int'(lowest(mp) < lowest(mi)));
      check("R4 vec_valid vs model", int'(vec_valid), int'(mvv));
      if (mvv) check("R4 vec_data vs model", int'(vec_data), mvd);
      check("R7 casc_ack vs model", int'(casc_ack), int'(mca));
    end
  end

  task automatic ack_vec(int line, string tag);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check(tag, int'(vec_valid), 1);
    check(tag, int'(vec_data), 8'h50 + line);
  endtask

  task automatic send_eoi(int line);
    eoi = 1'b1;
    eoi_line = 3'(line);
    @(negedge clk);
    eoi = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 intr in reset", int'(intr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 intr after reset", int'(intr), 0);
    check("R8 vec_valid after reset", int'(vec_valid), 0);
    check("R8 casc_ack after reset", int'(casc_ack), 0);

    // single request, held high after grant
    irq_req[5] = 1'b1;
    @(negedge clk);
    check("R3 intr on line 5", int'(intr), 1);
    ack_vec(5, "R4 vector line 5");
    check("R1 held level no retrigger", int'(intr), 0);
    send_eoi(5);
    check("R1 held level after eoi", int'(intr), 0);
    irq_req[5] = 1'b0;

    // simultaneous requests, lower number wins
    irq_req[6] = 1'b1; irq_req[3] = 1'b1;
    @(negedge clk);
    ack_vec(3, "R2 line 3 beats line 6");
    check("R5 lower priority blocked", int'(intr), 0);
    send_eoi(3);
    check("R6 eoi releases line 6", int'(intr), 1);
    ack_vec(6, "R4 vector line 6");
    send_eoi(6);
    irq_req = '0;

    // preemption and equal-priority blocking
    irq_req[4] = 1'b1;
    @(negedge clk);
    ack_vec(4, "R4 vector line 4");
    irq_req[4] = 1'b0; irq_req[1] = 1'b1;
    @(negedge clk);
    check("R5 higher priority preempts", int'(intr), 1);
    ack_vec(1, "R5 nested vector line 1");
    irq_req[4] = 1'b1;
    @(negedge clk);
    check("R5 equal priority blocked", int'(intr), 0);
    send_eoi(1);
    check("R5 equal priority still blocked", int'(intr), 0);
    send_eoi(4);
    check("R6 eoi line 4 releases", int'(intr), 1);
    ack_vec(4, "R4 second line 4");
    send_eoi(4);
    irq_req = '0;

    // eoi naming a line not in service
    irq_req[7] = 1'b1;
    @(negedge clk);
    ack_vec(7, "R4 vector line 7");
    irq_req[7] = 1'b0;
    @(negedge clk);
    irq_req[7] = 1'b1;
    @(negedge clk);
    send_eoi(3);
    check("R6 foreign eoi keeps line 7", int'(intr), 0);
    send_eoi(7);
    check("R6 eoi line 7 releases", int'(intr), 1);
    ack_vec(7, "R4 line 7 again");
    send_eoi(7);
    irq_req = '0;

    // cascade line
    irq_req[2] = 1'b1;
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check("R7 casc_ack on line 2", int'(casc_ack), 1);
    check("R7 no vector on line 2", int'(vec_valid), 0);
    send_eoi(2);
    irq_req = '0;

    // acknowledge with nothing pending
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check("R9 no vector on stray inta", int'(vec_valid), 0);
    check("R9 no casc_ack on stray inta", int'(casc_ack), 0);

    // one-cycle pulse stays pending
    irq_req[0] = 1'b1;
    @(negedge clk);
    irq_req[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 pulse stays pending", int'(intr), 1);
    ack_vec(0, "R4 vector line 0");
    send_eoi(0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule